// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps recently used virtual-to-physical page translations for a 32-bit virtual address space divided into 4 KB pages. A lookup presents a full virtual address. One clock later the block reports a hit or a miss. On a hit it also returns the physical address, which is the cached 20-bit frame number placed above the unchanged 12-bit page offset, together with the protection bits stored with that translation. Every stored tag is compared against the request in parallel, so any entry can hold any page.

Whatever handles a miss installs the missing translation through the fill port. The invalidate port removes one page when its mapping or protection changes. The flush input drops every translation at once when the address space changes. A fill first reuses an entry that already holds the same page. If there is none, it takes the lowest-numbered free entry. Only when no entry is free does it evict the least recently used one. Recency is kept as a per-entry age, and each lookup hit or fill sets the touched entry's age to zero.

A small occupancy state machine steers the choice of fill target. It has three states: OCC_EMPTY (no valid entry), OCC_PARTIAL (some entries valid, at least one free) and OCC_FULL (every entry valid). Its transitions are:
- OCC_EMPTY to OCC_PARTIAL on an accepted fill.
- OCC_PARTIAL to OCC_FULL when the last free entry is taken.
- OCC_PARTIAL to OCC_EMPTY when the last valid entry is invalidated.
- OCC_FULL to OCC_PARTIAL on an invalidate that hits.
- Any state to OCC_EMPTY on a flush.

In OCC_FULL the fill target is the oldest entry. In the other states it is a free entry.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and returns a physical address and protection value of zero.
- R2: A request with `lk_valid` high yields `lk_done` high exactly one cycle later. `lk_done` is low in a cycle that follows no request.
- R3: On a hit, `lk_paddr` equals {cached frame number, `lk_vaddr[11:0]`} and `lk_perm` equals the stored protection bits. On a miss both outputs are zero.
- R4: A fill makes its page hit from the next cycle on. A fill of a page that is already cached overwrites that entry in place, so a single invalidate then removes the page completely.
- R5: While any entry is free, a fill uses a free entry and evicts no valid translation.
- R6: A fill into a full cache evicts the valid entry whose last lookup hit or fill is the oldest.
- R7: A lookup hit makes its entry the most recently used, which protects it from the next eviction.
- R8: An invalidate clears only the entry holding the given page. An invalidate of a page that is not cached changes nothing.
- R9: A flush clears every entry in one cycle.
- R10: When a fill and an invalidate name the same page in the same cycle, the invalidate wins and the page is absent afterwards.
- R11: A lookup in the same cycle as a flush reports a miss. A fill in a flush cycle is discarded.
- R12: A lookup sees the contents from before the same cycle's fill, so a page filled in that cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| fill_perm | input | 4 | Protection bits stored with the entry |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| flush_all | input | 1 | Clear every entry |
| lk_done | output | 1 | Lookup result valid, one cycle after the request |
| lk_hit | output | 1 | The lookup found a translation |
| lk_paddr | output | 32 | Translated physical address, zero on a miss |
| lk_perm | output | 4 | Protection bits of the hit entry, zero on a miss |

## Verification
Lookups are tried with several different offsets under one cached page. This tells the offset pass-through apart from bits wrongly taken from the entry. The eviction scenario fills every entry in order, refreshes the first one with a hit, and then fills more pages. Which page disappears separates true least-recently-used replacement from fill-order or index-order replacement. A free entry is then opened while the cache is full, which shows whether free entries are used before eviction. Same-cycle combinations (fill with lookup, fill with invalidate of the same page, flush with lookup and fill) separate the defined priorities from their reverse.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 20;
    localparam int PA_W  = PFN_W + OFF_W;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_state_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               tag_vld,
    input  logic [N-1:0][VPN_W-1:0]    tag_q,
    input  logic [VPN_W-1:0]           key_lk,
    input  logic [VPN_W-1:0]           key_fill,
    input  logic [VPN_W-1:0]           key_inv,
    output logic [N-1:0]               m_lk,
    output logic [N-1:0]               m_fill,
    output logic [N-1:0]               m_inv,
    output logic [IDX_W-1:0]           idx_lk,
    output logic [IDX_W-1:0]           idx_fill
);
    function automatic logic [IDX_W-1:0] enc(input logic [N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            if (v[i]) r = r | IDX_W'(i);
        end
        return r;
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign m_lk[g]   = tag_vld[g] && (tag_q[g] == key_lk);
        assign m_fill[g] = tag_vld[g] && (tag_q[g] == key_fill);
        assign m_inv[g]  = tag_vld[g] && (tag_q[g] == key_inv);
    end

    assign idx_lk   = enc(m_lk);
    assign idx_fill = enc(m_fill);

    // R4
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_lk));
    // R4
    fill_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_fill));
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N),
    parameter int AW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_v,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             fill_v,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [IDX_W-1:0] lru_idx
);
    typedef logic [N-1:0][AW-1:0] age_vec_t;

    age_vec_t   age_q;
    age_vec_t   age_h;
    age_vec_t   age_d;
    logic [N-1:0] oldest;

    function automatic age_vec_t touch(input age_vec_t a, input logic [IDX_W-1:0] k);
        age_vec_t   res;
        logic [AW-1:0] pivot;
        pivot = a[k];
        for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == k)     res[i] = '0;
            else if (a[i] < pivot)  res[i] = a[i] + 1'b1;
            else                    res[i] = a[i];
        end
        return res;
    endfunction

    always_comb begin
        age_h = hit_v  ? touch(age_q, hit_idx)  : age_q;
        age_d = fill_v ? touch(age_h, fill_idx) : age_h;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
        end else begin
            age_q <= age_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_old
        assign oldest[g] = (age_q[g] == AW'(N - 1));
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (oldest[i]) lru_idx = lru_idx | IDX_W'(i);
        end
    end

    // R6
    lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);
    // R7
    hit_becomes_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v && !fill_v) |=> (age_q[$past(hit_idx)] == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N      = 32,
    parameter int PERM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_valid,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush_all,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PERM_W-1:0] lk_perm
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0]              vld_q, vld_d;
    logic [N-1:0][VPN_W-1:0]   tag_q;
    logic [N-1:0][PFN_W-1:0]   pfn_q;
    logic [N-1:0][PERM_W-1:0]  perm_q;

    occ_state_e occ_q, occ_d;

    logic [N-1:0]     m_lk, m_fill, m_inv;
    logic [IDX_W-1:0] idx_lk, idx_fill, lru_idx, free_idx, fill_tgt;
    logic             lk_fire, hit_now, inv_fire, fill_fire;
    logic [PFN_W-1:0]  hit_pfn;
    logic [PERM_W-1:0] hit_perm;

    xlat_cam #(.N(N), .IDX_W(IDX_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_vld  (vld_q),
        .tag_q    (tag_q),
        .key_lk   (lk_vaddr[VA_W-1:OFF_W]),
        .key_fill (fill_vpn),
        .key_inv  (inv_vpn),
        .m_lk     (m_lk),
        .m_fill   (m_fill),
        .m_inv    (m_inv),
        .idx_lk   (idx_lk),
        .idx_fill (idx_fill)
    );

    // Request qualification: flush beats everything, invalidate beats a same-page fill.
    always_comb begin
        lk_fire   = lk_valid && !flush_all;
        hit_now   = lk_fire && (|m_lk);
        inv_fire  = inv_valid && !flush_all;
        fill_fire = fill_valid && !flush_all && !(inv_valid && (fill_vpn == inv_vpn));
    end

    xlat_lru #(.N(N), .IDX_W(IDX_W), .AW(IDX_W)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_v    (hit_now),
        .hit_idx  (idx_lk),
        .fill_v   (fill_fire),
        .fill_idx (fill_tgt),
        .lru_idx  (lru_idx)
    );

    // Lowest-numbered free entry.
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_q[i]) free_idx = IDX_W'(i);
        end
    end

    // Output process of the occupancy machine: fill target selection.
    always_comb begin
        fill_tgt = free_idx;
        if (|m_fill) begin
            fill_tgt = idx_fill;
        end else begin
            unique case (occ_q)
                OCC_EMPTY:   fill_tgt = free_idx;
                OCC_PARTIAL: fill_tgt = free_idx;
                OCC_FULL:    fill_tgt = lru_idx;
                default:     fill_tgt = free_idx;
            endcase
        end
    end

    // Next valid vector.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (flush_all)                               vld_d[i] = 1'b0;
            else if (fill_fire && fill_tgt == IDX_W'(i)) vld_d[i] = 1'b1;
            else if (inv_fire && m_inv[i])               vld_d[i] = 1'b0;
            else                                         vld_d[i] = vld_q[i];
        end
    end

    // Next-state logic of the occupancy machine.
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (fill_fire) occ_d = (&vld_d) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (flush_all)          occ_d = OCC_EMPTY;
                else if (vld_d == '0)   occ_d = OCC_EMPTY;
                else if (&vld_d)        occ_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (flush_all)          occ_d = OCC_EMPTY;
                else if (vld_d == '0)   occ_d = OCC_EMPTY;
                else if (!(&vld_d))     occ_d = OCC_PARTIAL;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= OCC_EMPTY;
        else        occ_q <= occ_d;
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            tag_q  <= '0;
            pfn_q  <= '0;
            perm_q <= '0;
        end else begin
            vld_q <= vld_d;
            if (fill_fire) begin
                tag_q[fill_tgt]  <= fill_vpn;
                pfn_q[fill_tgt]  <= fill_pfn;
                perm_q[fill_tgt] <= fill_perm;
            end
        end
    end

    // Hit data: AND-OR selection over the one-hot match vector.
    always_comb begin
        hit_pfn  = '0;
        hit_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (m_lk[i]) begin
                hit_pfn  = hit_pfn  | pfn_q[i];
                hit_perm = hit_perm | perm_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_paddr <= '0;
            lk_perm  <= '0;
        end else begin
            lk_done  <= lk_valid;
            lk_hit   <= hit_now;
            lk_paddr <= hit_now ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
            lk_perm  <= hit_now ? hit_perm : '0;
        end
    end

    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);
    // R2
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_done);
    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_hit || lk_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && lk_perm == '0));
    // R11
    flush_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && flush_all) |=> !lk_hit);
    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_q == '0 && occ_q == OCC_EMPTY));
    // R5
    occ_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_FULL) == (&vld_q));
    // R5
    occ_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_EMPTY) == (vld_q == '0));
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [3:0]  fill_perm = '0;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_all = 1'b0;
    logic        lk_done, lk_hit;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_perm;

    int vectors = 0;
    int errs = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xlat_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_all(flush_all),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perm(lk_perm)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at a falling edge, release at the next one.
    task automatic op(input logic lv, input logic [31:0] va,
                      input logic fv, input logic [19:0] fvpn, input logic [19:0] fpfn, input logic [3:0] fpm,
                      input logic iv, input logic [19:0] ivpn, input logic fl);
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va;
        fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_perm = fpm;
        inv_valid = iv; inv_vpn = ivpn; flush_all = fl;
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; inv_valid = 0; flush_all = 0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [3:0] pm);
        op(0, '0, 1, vpn, pfn, pm, 0, '0, 0);
    endtask

    task automatic inval(input logic [19:0] vpn);
        op(0, '0, 0, '0, '0, '0, 1, vpn, 0);
    endtask

    task automatic expect_result(input string req, input logic hit, input logic [31:0] pa, input logic [3:0] pm);
        chk(req, {63'd0, lk_done}, 64'd1);
        chk(req, {63'd0, lk_hit}, {63'd0, hit});
        chk(req, {32'd0, lk_paddr}, {32'd0, pa});
        chk(req, {60'd0, lk_perm}, {60'd0, pm});
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic hit,
                        input logic [19:0] pfn, input logic [3:0] pm);
        op(1, va, 0, '0, '0, '0, 0, '0, 0);
        expect_result(req, hit, hit ? {pfn, va[11:0]} : 32'd0, hit ? pm : 4'd0);
    endtask

    task automatic t_reset;
        look("R1", 32'h0000_0000, 0, '0, '0);
        look("R1", 32'hFFFF_FABC, 0, '0, '0);
        @(negedge clk);
        chk("R2", {63'd0, lk_done}, 64'd0);
    endtask

    task automatic t_fill_hit;
        fill(20'h12345, 20'hABCDE, 4'h5);
        look("R3", 32'h1234_5678, 1, 20'hABCDE, 4'h5);
        look("R3", 32'h1234_5000, 1, 20'hABCDE, 4'h5);
        look("R3", 32'h1234_5FFF, 1, 20'hABCDE, 4'h5);
        look("R4", 32'h1234_6000, 0, '0, '0);
    endtask

    task automatic t_update_in_place;
        fill(20'h12345, 20'h0BEEF, 4'hA);
        look("R4", 32'h1234_5123, 1, 20'h0BEEF, 4'hA);
        inval(20'h12345);
        look("R4", 32'h1234_5123, 0, '0, '0);
    endtask

    task automatic t_same_cycle_fill_lookup;
        op(1, 32'h0007_7001, 1, 20'h00077, 20'h11111, 4'h3, 0, '0, 0);
        expect_result("R12", 0, 32'd0, 4'd0);
        look("R12", 32'h0007_7001, 1, 20'h11111, 4'h3);
    endtask

    task automatic t_invalidate;
        fill(20'h0000B, 20'h000BB, 4'h1);
        fill(20'h0000C, 20'h000CC, 4'h2);
        inval(20'h0000B);
        look("R8", 32'h0000_B010, 0, '0, '0);
        look("R8", 32'h0000_C010, 1, 20'h000CC, 4'h2);
        inval(20'h0000D);
        look("R8", 32'h0000_C020, 1, 20'h000CC, 4'h2);
    endtask

    task automatic t_fill_inv_same;
        op(0, '0, 1, 20'h000E0, 20'h00E0E, 4'h4, 1, 20'h000E0, 0);
        look("R10", 32'h000E_0004, 0, '0, '0);
        fill(20'h000E1, 20'h00E1E, 4'h4);
        op(0, '0, 1, 20'h000E1, 20'h00999, 4'h6, 1, 20'h000E1, 0);
        look("R10", 32'h000E_1004, 0, '0, '0);
    endtask

    task automatic t_flush;
        fill(20'h000F0, 20'h0F0F0, 4'h7);
        op(1, 32'h000F_0002, 0, '0, '0, '0, 0, '0, 1);
        expect_result("R11", 0, 32'd0, 4'd0);
        look("R9", 32'h0000_C000, 0, '0, '0);
        look("R9", 32'h0007_7000, 0, '0, '0);
        op(0, '0, 1, 20'h000F1, 20'h0F1F1, 4'h8, 0, '0, 1);
        look("R11", 32'h000F_1000, 0, '0, '0);
    endtask

    task automatic t_lru;
        op(0, '0, 0, '0, '0, '0, 0, '0, 1);
        for (int i = 0; i < 32; i++) fill(20'h100 + 20'(i), 20'h200 + 20'(i), 4'(i));
        for (int i = 0; i < 32; i += 7)
            look("R5", {20'h100 + 20'(i), 12'h010}, 1, 20'h200 + 20'(i), 4'(i));
        // refresh 0x100 so 0x101 is oldest (0x107, 0x10E, 0x115, 0x11C were also touched)
        look("R7", 32'h0010_0000, 1, 20'h200, 4'h0);
        fill(20'h300, 20'h400, 4'hC);
        look("R6", 32'h0010_1000, 0, '0, '0);
        look("R7", 32'h0010_0000, 1, 20'h200, 4'h0);
        look("R6", 32'h0030_0ABC, 1, 20'h400, 4'hC);
        look("R6", 32'h0010_2000, 1, 20'h202, 4'h2);
        // oldest is now 0x103; opening a free slot must spare it
        inval(20'h105);
        fill(20'h301, 20'h401, 4'hD);
        look("R5", 32'h0010_3000, 1, 20'h203, 4'h3);
        look("R5", 32'h0030_1000, 1, 20'h401, 4'hD);
        // full again, oldest is 0x104
        fill(20'h302, 20'h402, 4'hE);
        look("R6", 32'h0010_4000, 0, '0, '0);
        look("R6", 32'h0010_6000, 1, 20'h206, 4'h6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {63'd0, lk_done}, 64'd0);
        rst_n = 1'b1;
        t_reset;
        t_fill_hit;
        t_update_in_place;
        t_same_cycle_fill_lookup;
        t_invalidate;
        t_fill_inv_same;
        t_flush;
        t_lru;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule